// File: doc/BRIEF.md
# Tracklet Linear Fit Accumulator

This block collects the moment sums that a least-squares straight-line fit needs. Each fit is made from the hits seen by one candidate during a drift-time acquisition. Upstream logic evaluates every group of three adjacent readout channels and supplies three things per group on each timebin strobe: a hit flag, an unsigned sub-pad position and a charge value. Of the groups that flag a hit in a strobe, the block takes up to `NUM_CAND` and assigns them to candidate slots in ascending group order. Any further hits in that strobe are dropped. For each slot it adds to seven running sums: the hit count, the timebin, the position, timebin times position, position squared, timebin squared and charge.

The timebin index is generated inside the block. It counts the strobes accepted since the last clear, starting at 0. After 2^`TB_W` accepted strobes the acquisition window is full, and further strobes are ignored until the next clear. The accumulators are sized from the parameters so that a full window of maximal inputs cannot overflow.

The sums sit in a register file that processors can only read. A read takes a candidate index and a sum code, and the addressed sum appears one clock later on a 32-bit output. Software computes the slope, intercept and fit quality from these sums once the drift time has ended.

Top module: `tracklet_fit_accum`

## Requirements
- R1: After `rst`, or in the cycle after `clear` is high, every sum of every candidate slot reads as 0.
- R2: Sums change only on a clock edge where `tb_strobe` is high and `clear` is low. When `clear` and `tb_strobe` are high together, the strobe is ignored and the clear takes effect.
- R3: In an accepted strobe, slot k (counting from 0) receives the k-th lowest-numbered group whose hit flag is set. When more than `NUM_CAND` groups are flagged, the higher-numbered groups are dropped.
- R4: Sum code 0 is the hit count: the number of accepted strobes in which the slot received a group.
- R5: The timebin x is the number of strobes accepted since the last clear or reset, starting at 0. Sum code 1 accumulates x and sum code 5 accumulates x*x, for each strobe that fills the slot.
- R6: With y the position of the group in the slot, sum code 2 accumulates y, sum code 3 accumulates x*y and sum code 4 accumulates y*y.
- R7: Sum code 6 accumulates the charge of the group in the slot.
- R8: After 2^`TB_W` accepted strobes, further strobes leave every sum unchanged until the next clear.
- R9: `rd_data` returns the sum addressed by `rd_cand` and `rd_sel` one clock edge after they are presented. Sum code 7 returns 0. Reads never alter any sum.
- R10: A full window of strobes with every group hit, maximal position and maximal charge produces exact sums with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Zeroes all sums and the timebin counter at the start of an event |
| tb_strobe | input | 1 | One pulse per timebin during the drift time |
| grp_hit | input | NUM_CH-2 | Hit flag per three-channel group |
| grp_pos | input | (NUM_CH-2)*POS_W | Unsigned position per group, group g at bits g*POS_W upward |
| grp_q | input | (NUM_CH-2)*Q_W | Unsigned charge per group, group g at bits g*Q_W upward |
| rd_cand | input | clog2(NUM_CAND) | Candidate slot to read |
| rd_sel | input | 3 | Sum code (0 count, 1 x, 2 y, 3 xy, 4 yy, 5 xx, 6 charge, 7 none) |
| rd_data | output | 32 | Registered read data, zero-extended |

## Verification
The bench builds the block with its defaults: ten channels (eight groups), four candidate slots, a 6-bit timebin, 8-bit positions and 10-bit charges. With eight groups and four slots, random hit patterns regularly flag more groups than there are slots, which exercises the drop rule. A 64-timebin window is short enough to fill completely, run past its end and then saturate with maximal values. That tests the window limit and the accumulator sizing at their extremes.

// File: rtl/tfa_pkg.sv
package tfa_pkg;

  // Sum codes: the read select value equals the sum index.
  localparam int SUM_N    = 0;
  localparam int SUM_X    = 1;
  localparam int SUM_Y    = 2;
  localparam int SUM_XY   = 3;
  localparam int SUM_YY   = 4;
  localparam int SUM_XX   = 5;
  localparam int SUM_Q    = 6;
  localparam int NUM_SUMS = 7;

  // Widest single term, plus TB_W bits of headroom for 2**TB_W additions, plus one spare.
  function automatic int acc_width(input int tb_w, input int pos_w, input int q_w);
    int m;
    m = 2 * pos_w;
    if (2 * tb_w > m)     m = 2 * tb_w;
    if (pos_w + tb_w > m) m = pos_w + tb_w;
    if (q_w > m)          m = q_w;
    return m + tb_w + 1;
  endfunction

endpackage

// File: rtl/tfa_cand_select.sv
module tfa_cand_select #(
  parameter int NGRP     = 8,
  parameter int NUM_CAND = 4,
  parameter int POS_W    = 8,
  parameter int Q_W      = 10
) (
  input  logic [NGRP-1:0]                 grp_hit,
  input  logic [NGRP*POS_W-1:0]           grp_pos,
  input  logic [NGRP*Q_W-1:0]             grp_q,
  output logic [NUM_CAND-1:0]             slot_vld,
  output logic [NUM_CAND-1:0][POS_W-1:0]  slot_pos,
  output logic [NUM_CAND-1:0][Q_W-1:0]    slot_q
);

  localparam int CAND_W = (NUM_CAND > 1) ? $clog2(NUM_CAND) : 1;
  localparam logic [CAND_W:0] CAND_LIM = NUM_CAND[CAND_W:0];

  // Rank-order packing: the k-th flagged group lands in slot k.
  always_comb begin
    logic [CAND_W:0] taken;
    taken    = '0;
    slot_vld = '0;
    slot_pos = '0;
    slot_q   = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (grp_hit[g] && (taken < CAND_LIM)) begin
        slot_vld[taken[CAND_W-1:0]] = 1'b1;
        slot_pos[taken[CAND_W-1:0]] = grp_pos[g*POS_W +: POS_W];
        slot_q[taken[CAND_W-1:0]]   = grp_q[g*Q_W +: Q_W];
        taken = taken + 1'b1;
      end
    end
  end

endmodule

// File: rtl/tfa_moment_acc.sv
module tfa_moment_acc #(
  parameter int TB_W  = 6,
  parameter int POS_W = 8,
  parameter int Q_W   = 10,
  parameter int ACC_W = 24
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     clear,
  input  logic                                     upd,
  input  logic [TB_W-1:0]                          x,
  input  logic [POS_W-1:0]                         y,
  input  logic [Q_W-1:0]                           q,
  output logic [tfa_pkg::NUM_SUMS-1:0][ACC_W-1:0]  sums
);

  import tfa_pkg::*;

  logic [ACC_W-1:0] xe, ye, qe;
  assign xe = ACC_W'(x);
  assign ye = ACC_W'(y);
  assign qe = ACC_W'(q);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sums <= '0;
    end else if (upd) begin
      sums[SUM_N]  <= sums[SUM_N]  + ACC_W'(1);
      sums[SUM_X]  <= sums[SUM_X]  + xe;
      sums[SUM_Y]  <= sums[SUM_Y]  + ye;
      sums[SUM_XY] <= sums[SUM_XY] + xe * ye;
      sums[SUM_YY] <= sums[SUM_YY] + ye * ye;
      sums[SUM_XX] <= sums[SUM_XX] + xe * xe;
      sums[SUM_Q]  <= sums[SUM_Q]  + qe;
    end
  end

endmodule

// File: rtl/tracklet_fit_accum.sv
module tracklet_fit_accum #(
  parameter int NUM_CH   = 10,
  parameter int NUM_CAND = 4,
  parameter int TB_W     = 6,
  parameter int POS_W    = 8,
  parameter int Q_W      = 10,
  parameter int RD_W     = 32,
  localparam int NGRP    = NUM_CH - 2,
  localparam int CAND_W  = (NUM_CAND > 1) ? $clog2(NUM_CAND) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clear,
  input  logic                     tb_strobe,
  input  logic [NGRP-1:0]          grp_hit,
  input  logic [NGRP*POS_W-1:0]    grp_pos,
  input  logic [NGRP*Q_W-1:0]      grp_q,
  input  logic [CAND_W-1:0]        rd_cand,
  input  logic [2:0]               rd_sel,
  output logic [RD_W-1:0]          rd_data
);

  import tfa_pkg::*;

  localparam int ACC_W = acc_width(TB_W, POS_W, Q_W);

  logic [NUM_CAND-1:0]                             slot_vld;
  logic [NUM_CAND-1:0][POS_W-1:0]                  slot_pos;
  logic [NUM_CAND-1:0][Q_W-1:0]                    slot_q;
  logic [NUM_CAND-1:0][NUM_SUMS-1:0][ACC_W-1:0]    acc_sums;
  logic [TB_W:0]                                   tb_cnt;
  logic                                            win_full;
  logic                                            accept;

  assign win_full = tb_cnt[TB_W];
  assign accept   = tb_strobe & ~clear & ~win_full;

  // Timebin index: strobes accepted since the last clear.
  always_ff @(posedge clk) begin
    if (rst || clear) tb_cnt <= '0;
    else if (accept)  tb_cnt <= tb_cnt + 1'b1;
  end

  tfa_cand_select #(
    .NGRP(NGRP), .NUM_CAND(NUM_CAND), .POS_W(POS_W), .Q_W(Q_W)
  ) u_sel (
    .grp_hit(grp_hit), .grp_pos(grp_pos), .grp_q(grp_q),
    .slot_vld(slot_vld), .slot_pos(slot_pos), .slot_q(slot_q)
  );

  for (genvar k = 0; k < NUM_CAND; k++) begin : g_slot
    tfa_moment_acc #(
      .TB_W(TB_W), .POS_W(POS_W), .Q_W(Q_W), .ACC_W(ACC_W)
    ) u_acc (
      .clk(clk), .rst(rst), .clear(clear),
      .upd(accept & slot_vld[k]),
      .x(tb_cnt[TB_W-1:0]), .y(slot_pos[k]), .q(slot_q[k]),
      .sums(acc_sums[k])
    );
  end

  // Read-only port, registered.
  always_ff @(posedge clk) begin
    if (rst)                        rd_data <= '0;
    else if (rd_sel == 3'd7)        rd_data <= '0;
    else                            rd_data <= RD_W'(acc_sums[rd_cand][rd_sel]);
  end

endmodule

// File: rtl/tfa_checker.sv
module tfa_checker #(
  parameter int NGRP     = 8,
  parameter int NUM_CAND = 4,
  parameter int TB_W     = 6,
  parameter int SUM_BITS = 8,
  parameter int RD_W     = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                clear,
  input logic                tb_strobe,
  input logic [NGRP-1:0]     grp_hit,
  input logic [2:0]          rd_sel,
  input logic [RD_W-1:0]     rd_data,
  input logic [NUM_CAND-1:0] slot_vld,
  input logic [SUM_BITS-1:0] all_sums,
  input logic [TB_W:0]       tb_cnt
);

  // R1
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> (all_sums == '0));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tb_strobe && !clear) |=> $stable(all_sums));

  // R8
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tb_cnt[TB_W] && !clear) |=> $stable(all_sums));

  // R3
  rank_select_chk: assert property (@(posedge clk) disable iff (rst)
    tb_strobe |-> ($countones(slot_vld) ==
      (($countones(grp_hit) > NUM_CAND) ? NUM_CAND : $countones(grp_hit))));

  // R9
  rd_none_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == 3'd7) |=> (rd_data == '0));

  // R5
  tb_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tb_strobe && !clear && !tb_cnt[TB_W]) |=> (tb_cnt == $past(tb_cnt) + 1'b1));

endmodule

bind tracklet_fit_accum tfa_checker #(
  .NGRP(NGRP), .NUM_CAND(NUM_CAND), .TB_W(TB_W),
  .SUM_BITS(NUM_CAND * tfa_pkg::NUM_SUMS * ACC_W), .RD_W(RD_W)
) u_tfa_checker (
  .clk(clk), .rst(rst), .clear(clear), .tb_strobe(tb_strobe),
  .grp_hit(grp_hit), .rd_sel(rd_sel), .rd_data(rd_data),
  .slot_vld(slot_vld), .all_sums(acc_sums), .tb_cnt(tb_cnt)
);

// File: tb/test_tracklet_fit_accum.sv
module test_tracklet_fit_accum;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH   = 10;
  localparam int NUM_CAND = 4;
  localparam int TB_W     = 6;
  localparam int POS_W    = 8;
  localparam int Q_W      = 10;
  localparam int NGRP     = NUM_CH - 2;
  localparam int WIN      = 1 << TB_W;

  logic clk = 1'b0;
  logic rst, clear, tb_strobe;
  logic [NGRP-1:0]       grp_hit;
  logic [NGRP*POS_W-1:0] grp_pos;
  logic [NGRP*Q_W-1:0]   grp_q;
  logic [1:0]            rd_cand;
  logic [2:0]            rd_sel;
  logic [31:0]           rd_data;

  int checks = 0;
  int fails  = 0;
  longint exp_sum [NUM_CAND][8];
  int exp_tb;

  always #(CLK_PERIOD/2) clk = ~clk;

  tracklet_fit_accum #(
    .NUM_CH(NUM_CH), .NUM_CAND(NUM_CAND), .TB_W(TB_W), .POS_W(POS_W), .Q_W(Q_W)
  ) i_tracklet_fit_accum (
    .clk(clk), .rst(rst), .clear(clear), .tb_strobe(tb_strobe),
    .grp_hit(grp_hit), .grp_pos(grp_pos), .grp_q(grp_q),
    .rd_cand(rd_cand), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  function automatic void model_zero();
    for (int c = 0; c < NUM_CAND; c++)
      for (int s = 0; s < 8; s++) exp_sum[c][s] = 0;
    exp_tb = 0;
  endfunction

  // Requirement model: clear priority, rank packing, window limit, moment sums.
  function automatic void model_edge(input bit clr, input bit stb);
    int taken;
    longint x, y, q;
    if (clr) begin model_zero(); return; end
    if (!stb || exp_tb >= WIN) return;
    taken = 0;
    x = exp_tb;
    for (int g = 0; g < NGRP; g++) begin
      if (grp_hit[g] && taken < NUM_CAND) begin
        y = longint'(grp_pos[g*POS_W +: POS_W]);
        q = longint'(grp_q[g*Q_W +: Q_W]);
        exp_sum[taken][0] += 1;
        exp_sum[taken][1] += x;
        exp_sum[taken][2] += y;
        exp_sum[taken][3] += x * y;
        exp_sum[taken][4] += y * y;
        exp_sum[taken][5] += x * x;
        exp_sum[taken][6] += q;
        taken++;
      end
    end
    exp_tb++;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a negedge; leaves at the next negedge.
  task automatic cycle(input bit clr, input bit stb);
    clear = clr;
    tb_strobe = stb;
    @(posedge clk);
    model_edge(clr, stb);
    @(negedge clk);
    clear = 1'b0;
    tb_strobe = 1'b0;
  endtask

  task automatic rand_inputs(input int hit_pct, input bit maxval);
    for (int g = 0; g < NGRP; g++) begin
      grp_hit[g] = (($urandom % 100) < hit_pct);
      grp_pos[g*POS_W +: POS_W] = maxval ? '1 : POS_W'($urandom);
      grp_q[g*Q_W +: Q_W]       = maxval ? '1 : Q_W'($urandom);
    end
  endtask

  task automatic read_all(input string req);
    for (int c = 0; c < NUM_CAND; c++) begin
      for (int s = 0; s < 8; s++) begin
        rd_cand = 2'(c);
        rd_sel  = 3'(s);
        @(posedge clk);
        @(negedge clk);
        check(req, longint'(rd_data), (s == 7) ? 64'd0 : exp_sum[c][s]);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1; clear = 1'b0; tb_strobe = 1'b0;
    grp_hit = '0; grp_pos = '0; grp_q = '0; rd_cand = '0; rd_sel = '0;
    model_zero();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1 reset rd_data", longint'(rd_data), 0);
    read_all("R1 reset sums");

    // R4 R5 R6 R7 R2 R3: random events with idle cycles between strobes
    for (int ev = 0; ev < 6; ev++) begin
      int n_tb;
      cycle(1'b1, 1'b0);
      n_tb = 8 + int'($urandom % 50);
      for (int t = 0; t < n_tb; t++) begin
        rand_inputs(35 + ev * 10, 1'b0);
        cycle(1'b0, ($urandom % 4) != 0);
      end
      read_all("R4 R5 R6 R7 R2 R3 random event");
    end

    // R3: all groups hit, only the four lowest kept
    cycle(1'b1, 1'b0);
    grp_hit = '1;
    for (int g = 0; g < NGRP; g++) begin
      grp_pos[g*POS_W +: POS_W] = POS_W'(10 * (g + 1));
      grp_q[g*Q_W +: Q_W]       = Q_W'(100 + g);
    end
    cycle(1'b0, 1'b1);
    cycle(1'b0, 1'b1);
    read_all("R3 overflow groups dropped");
    rd_cand = 2'd3; rd_sel = 3'd2;
    @(posedge clk); @(negedge clk);
    check("R3 slot3 takes group3 position", longint'(rd_data), 80);

    // R2: strobe together with clear is ignored
    cycle(1'b1, 1'b1);
    read_all("R2 clear beats strobe");

    // R8 R10: overrun the window with maximal values
    cycle(1'b1, 1'b0);
    rand_inputs(100, 1'b1);
    for (int t = 0; t < WIN + 6; t++) cycle(1'b0, 1'b1);
    read_all("R8 R10 full window");
    rd_cand = 2'd0; rd_sel = 3'd4;
    @(posedge clk); @(negedge clk);
    check("R10 yy exact", longint'(rd_data), 64'd64 * 255 * 255);
    rd_sel = 3'd0;
    @(posedge clk); @(negedge clk);
    check("R8 count capped", longint'(rd_data), WIN);

    // R9: one-cycle latency and code 7
    rd_cand = 2'd1; rd_sel = 3'd6;
    @(posedge clk); @(negedge clk);
    rd_sel = 3'd7;
    #1;
    check("R9 before edge holds old value", longint'(rd_data), exp_sum[1][6]);
    @(posedge clk); @(negedge clk);
    check("R9 code 7 reads zero", longint'(rd_data), 0);
    read_all("R9 reads leave sums intact");

    // R1: clear after data
    cycle(1'b1, 1'b0);
    read_all("R1 clear zeroes sums");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule